// File: doc/BRIEF.md
# Ethernet PHY Management Register File with Indirect Banks

This block is the management-side register file of an Ethernet PHY. A host drives a simple register port (5-bit address, 16-bit write data, separate write and read strobes) and gets registered read data one clock later. Only three direct addresses are decoded. Every other direct address is inert.

The direct addresses open two indirect paths. The first is a multiplexed shadow access register. Its top bit decides between two actions: performing a write into a hidden 10-bit shadow register, or only choosing which shadow register later reads return. The second is an expansion window made of a select register and a data register. The upper byte of the select value picks either a secondary SerDes bank or a general expansion bank, and the lower byte picks the register within that bank. Any other upper byte closes the window.

Fields of the hidden registers drive level control outputs: secondary SerDes enable, its use as an LED source, its power-down, SGMII slave mode and slave auto-detection, the switch to the 1000BASE-X register set, and two 4-bit LED source codes. Firmware brings a port up in fiber mode by a series of read-modify-write sequences through these windows.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: During and after reset, all control outputs are 0 except `serdes2_pwrdn`, which is 1. `reg_rvalid` and `reg_rdata` are 0.
- R2: A read strobe sampled at clock edge N gives `reg_rvalid`=1 and the read value on `reg_rdata` after edge N. A cycle without a read strobe gives `reg_rvalid`=0 and `reg_rdata`=0.
- R3: Every write to direct address 0x1C latches bits [14:10] as the shadow selector. When bit 15 is 1, the write also stores bits [9:0] into the shadow register that those selector bits name.
- R4: A read of 0x1C returns bit 15 = 0, the latched selector in bits [14:10], and the selected shadow register's contents in bits [9:0].
- R5: Shadow 0x14 bit 0 drives `serdes2_en` and bit 3 drives `serdes2_led_src`. Shadow 0x1F bit 0 drives `basex_mode`. Shadow 0x0D bits [3:0] drive `led1_src` and bits [7:4] drive `led3_src`.
- R6: Shadow selectors other than 0x0D, 0x14 and 0x1F read 0 in bits [9:0], and writes to them change no output.
- R7: Direct address 0x17 holds the 16-bit expansion select value and reads it back. Upper byte 0x0E targets the secondary SerDes bank, upper byte 0x0F targets the general bank, and the low byte is the register number.
- R8: Reads and writes of direct address 0x15 act on the register that 0x17 chooses. With any other upper byte, reads return 0 and writes have no effect.
- R9: In the SerDes bank, register 0x00 resets to 0x0800 and its bit 11 drives `serdes2_pwrdn`. In register 0x15, bit 1 drives `sgmii_slave_en` and bit 0 drives `sgmii_autodet`. Both registers hold all 16 bits. Other SerDes register numbers read 0.
- R10: General bank register numbers below GEN_DEPTH store 16 bits and reset to 0. Higher numbers read 0 and ignore writes.
- R11: Direct addresses other than 0x15, 0x17 and 0x1C read 0 and ignore writes.
- R12: When read and write strobes hit the same address in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Direct register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one clock after the strobe |
| serdes2_en | output | 1 | Secondary SerDes enable |
| serdes2_led_src | output | 1 | Secondary SerDes acts as LED source |
| serdes2_pwrdn | output | 1 | Secondary SerDes power-down |
| sgmii_slave_en | output | 1 | SGMII slave mode enable |
| sgmii_autodet | output | 1 | SGMII slave auto-detection enable |
| basex_mode | output | 1 | 1000BASE-X register set selected |
| led1_src | output | 4 | Source code for LED1 |
| led3_src | output | 4 | Source code for LED3 |

## Verification
Every bit of hidden state drives a level output or can be read back through a window. A corrupted shadow, SerDes or general register therefore shows on a control pin right after the offending edge, or in `reg_rdata` one clock after the next read that reaches it. A wrong selector latch or bank decode shows on the first read of 0x1C or 0x15 that follows. For that reason the reference model is compared on every cycle, and the stimulus keeps reading through both windows, including while the expansion window is closed.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;

  // direct addresses
  localparam logic [ADDR_W-1:0] A_EXP_DATA = 5'h15;
  localparam logic [ADDR_W-1:0] A_EXP_SEL  = 5'h17;
  localparam logic [ADDR_W-1:0] A_SHADOW   = 5'h1C;

  // shadow access register layout
  localparam int SH_SEL_W  = 5;
  localparam int SH_DATA_W = 10;
  localparam int SH_SEL_LSB = SH_DATA_W;
  localparam int SH_SEL_MSB = SH_DATA_W + SH_SEL_W - 1;
  localparam int SH_WFLAG   = DATA_W - 1;

  // implemented shadow registers
  localparam int SH_COUNT  = 3;
  localparam int SHI_LED   = 0;
  localparam int SHI_S2    = 1;
  localparam int SHI_MODE  = 2;
  localparam logic [SH_SEL_W-1:0] SH_LED  = 5'h0D;
  localparam logic [SH_SEL_W-1:0] SH_S2   = 5'h14;
  localparam logic [SH_SEL_W-1:0] SH_MODE = 5'h1F;

  // expansion window
  localparam int BANK_W = 8;
  localparam int REGN_W = 8;
  localparam logic [BANK_W-1:0] BANK_SERDES2 = 8'h0E;
  localparam logic [BANK_W-1:0] BANK_GEN     = 8'h0F;
  localparam logic [REGN_W-1:0] S2_CTRL  = 8'h00;
  localparam logic [REGN_W-1:0] S2_SLAVE = 8'h15;
  localparam logic [DATA_W-1:0] S2_CTRL_RST = 16'h0800;
  localparam int S2_PWRDN_BIT = 11;

  typedef struct packed {
    logic       s2_en;
    logic       s2_led;
    logic       basex;
    logic [3:0] led1;
    logic [3:0] led3;
  } shadow_ctl_t;

  function automatic logic [SH_SEL_W-1:0] sh_addr(input int idx);
    case (idx)
      SHI_LED: return SH_LED;
      SHI_S2:  return SH_S2;
      default: return SH_MODE;
    endcase
  endfunction
endpackage

// File: rtl/pm_shadow_bank.sv
module pm_shadow_bank
  import phymgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [SH_SEL_W-1:0]  sel,
  output logic [SH_DATA_W-1:0] rdata,
  output shadow_ctl_t          ctl
);
  logic [SH_DATA_W-1:0] sh_q [SH_COUNT];
  logic [SH_COUNT-1:0]  rd_hit;
  logic [SH_COUNT-1:0]  wr_hit;
  logic [SH_SEL_W-1:0]  wsel;
  logic                 wflag;

  assign wsel  = wdata[SH_SEL_MSB:SH_SEL_LSB];
  assign wflag = wdata[SH_WFLAG];

  for (genvar g = 0; g < SH_COUNT; g++) begin : g_dec
    assign rd_hit[g] = (sel == sh_addr(g));
    assign wr_hit[g] = wr && wflag && (wsel == sh_addr(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      for (int i = 0; i < SH_COUNT; i++) sh_q[i] <= '0;
    end else begin
      if (wr) sel <= wsel;
      for (int i = 0; i < SH_COUNT; i++)
        if (wr_hit[i]) sh_q[i] <= wdata[SH_DATA_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < SH_COUNT; i++)
      if (rd_hit[i]) rdata = rdata | sh_q[i];
  end

  assign ctl.s2_en  = sh_q[SHI_S2][0];
  assign ctl.s2_led = sh_q[SHI_S2][3];
  assign ctl.basex  = sh_q[SHI_MODE][0];
  assign ctl.led1   = sh_q[SHI_LED][3:0];
  assign ctl.led3   = sh_q[SHI_LED][7:4];

  // R6: a write naming an unimplemented selector leaves every output alone
  p_unimpl_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (wr && wflag && (wr_hit == '0)) |=> $stable(ctl));

  // R5: LED selector write reaches both LED codes
  p_led_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && wflag && (wsel == SH_LED)) |=>
      (ctl.led1 == $past(wdata[3:0]) && ctl.led3 == $past(wdata[7:4])));

  // R3: a select-only write keeps shadow contents
  p_select_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && !wflag) |=> $stable(ctl));
endmodule

// File: rtl/pm_gen_bank.sv
module pm_gen_bank
  import phymgmt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REGN_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;
  logic [IDX_W-1:0]  slot;

  assign in_range = (int'(idx) < DEPTH);
  assign slot     = IDX_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[slot] <= wdata;
    end
  end

  assign rdata = in_range ? mem[slot] : '0;

  initial begin
    a_depth_fits_r10: assert (DEPTH >= 1 && DEPTH <= (1 << REGN_W));
  end
endmodule

// File: rtl/pm_exp_window.sv
module pm_exp_window
  import phymgmt_pkg::*;
#(
  parameter int GEN_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sel,
  output logic [DATA_W-1:0] rdata,
  output logic              pwrdn,
  output logic              slave_en,
  output logic              autodet
);
  logic [BANK_W-1:0] bank;
  logic [REGN_W-1:0] regn;
  logic              s2_hit, gen_hit;
  logic [DATA_W-1:0] s2_ctrl_q, s2_slave_q, gen_rdata, s2_rdata;

  assign bank    = sel[DATA_W-1:REGN_W];
  assign regn    = sel[REGN_W-1:0];
  assign s2_hit  = (bank == BANK_SERDES2);
  assign gen_hit = (bank == BANK_GEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= '0;
      s2_ctrl_q  <= S2_CTRL_RST;
      s2_slave_q <= '0;
    end else begin
      if (sel_wr) sel <= wdata;
      if (data_wr && s2_hit && regn == S2_CTRL)  s2_ctrl_q  <= wdata;
      if (data_wr && s2_hit && regn == S2_SLAVE) s2_slave_q <= wdata;
    end
  end

  pm_gen_bank #(.DEPTH(GEN_DEPTH)) u_gen (
    .clk   (clk),
    .rst   (rst),
    .we    (data_wr && gen_hit),
    .idx   (regn),
    .wdata (wdata),
    .rdata (gen_rdata)
  );

  always_comb begin
    case (regn)
      S2_CTRL:  s2_rdata = s2_ctrl_q;
      S2_SLAVE: s2_rdata = s2_slave_q;
      default:  s2_rdata = '0;
    endcase
  end

  assign rdata    = s2_hit ? s2_rdata : (gen_hit ? gen_rdata : '0);
  assign pwrdn    = s2_ctrl_q[S2_PWRDN_BIT];
  assign slave_en = s2_slave_q[1];
  assign autodet  = s2_slave_q[0];

  // R8: data writes through a closed window leave the SerDes controls alone
  p_closed_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !s2_hit && !gen_hit) |=> ($stable(pwrdn) && $stable(slave_en) && $stable(autodet)));

  // R9: power-down follows bit 11 of a SerDes control write
  p_pwrdn_write_r9: assert property (@(posedge clk) disable iff (rst)
    (data_wr && s2_hit && regn == S2_CTRL) |=> (pwrdn == $past(wdata[S2_PWRDN_BIT])));

  // R7: a rewrite of the select register is visible on the next cycle
  p_sel_load_r7: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (sel == $past(wdata)));
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phymgmt_pkg::*;
#(
  parameter int GEN_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              serdes2_en,
  output logic              serdes2_led_src,
  output logic              serdes2_pwrdn,
  output logic              sgmii_slave_en,
  output logic              sgmii_autodet,
  output logic              basex_mode,
  output logic [3:0]        led1_src,
  output logic [3:0]        led3_src
);
  logic [SH_SEL_W-1:0]  sh_sel;
  logic [SH_DATA_W-1:0] sh_rdata;
  shadow_ctl_t          sh_ctl;
  logic [DATA_W-1:0]    exp_sel, exp_rdata, rd_mux;

  pm_shadow_bank u_shadow (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr && reg_addr == A_SHADOW),
    .wdata (reg_wdata),
    .sel   (sh_sel),
    .rdata (sh_rdata),
    .ctl   (sh_ctl)
  );

  pm_exp_window #(.GEN_DEPTH(GEN_DEPTH)) u_exp (
    .clk      (clk),
    .rst      (rst),
    .sel_wr   (reg_wr && reg_addr == A_EXP_SEL),
    .data_wr  (reg_wr && reg_addr == A_EXP_DATA),
    .wdata    (reg_wdata),
    .sel      (exp_sel),
    .rdata    (exp_rdata),
    .pwrdn    (serdes2_pwrdn),
    .slave_en (sgmii_slave_en),
    .autodet  (sgmii_autodet)
  );

  always_comb begin
    case (reg_addr)
      A_SHADOW:   rd_mux = {1'b0, sh_sel, sh_rdata};
      A_EXP_SEL:  rd_mux = exp_sel;
      A_EXP_DATA: rd_mux = exp_rdata;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_mux : '0;
    end
  end

  assign serdes2_en      = sh_ctl.s2_en;
  assign serdes2_led_src = sh_ctl.s2_led;
  assign basex_mode      = sh_ctl.basex;
  assign led1_src        = sh_ctl.led1;
  assign led3_src        = sh_ctl.led3;

  // R2: no strobe, no valid and a quiet data bus
  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (!reg_rvalid && reg_rdata == '0));

  // R4: shadow readback never sets the top bit and echoes the selector
  p_shadow_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_SHADOW) |=>
      (!reg_rdata[SH_WFLAG] && reg_rdata[SH_SEL_MSB:SH_SEL_LSB] == $past(sh_sel)));
endmodule

// File: tb/phy_mgmt_regfile_bench.sv
module phy_mgmt_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GEN_DEPTH  = 16;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid, serdes2_en, serdes2_led_src, serdes2_pwrdn;
  logic        sgmii_slave_en, sgmii_autodet, basex_mode;
  logic [3:0]  led1_src, led3_src;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  int m_shsel;
  int m_sh [32];
  int m_esel, m_s2c, m_s2s;
  int m_gen [256];
  int m_rd, m_rdv;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_regfile #(.GEN_DEPTH(GEN_DEPTH)) u_phy_mgmt_regfile (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .serdes2_en(serdes2_en), .serdes2_led_src(serdes2_led_src),
    .serdes2_pwrdn(serdes2_pwrdn), .sgmii_slave_en(sgmii_slave_en),
    .sgmii_autodet(sgmii_autodet), .basex_mode(basex_mode),
    .led1_src(led1_src), .led3_src(led3_src)
  );

  function automatic bit sh_impl(int s);
    return (s == 'h0D) || (s == 'h14) || (s == 'h1F);
  endfunction

  function automatic int exp_read();
    int bank = (m_esel >> 8) & 255;
    int r = m_esel & 255;
    if (bank == 'h0E) return (r == 0) ? m_s2c : ((r == 'h15) ? m_s2s : 0);
    if (bank == 'h0F) return (r < GEN_DEPTH) ? m_gen[r] : 0;
    return 0;
  endfunction

  function automatic int model_read(int a);
    case (a)
      'h1C: return (m_shsel << 10) | (sh_impl(m_shsel) ? m_sh[m_shsel] : 0);
      'h17: return m_esel;
      'h15: return exp_read();
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_shsel = 0; m_esel = 0; m_s2c = 'h0800; m_s2s = 0; m_rd = 0; m_rdv = 0;
    for (int i = 0; i < 32; i++) m_sh[i] = 0;
    for (int i = 0; i < 256; i++) m_gen[i] = 0;
  endtask

  task automatic model_write(int a, int d);
    int bank, r;
    if (a == 'h1C) begin
      m_shsel = (d >> 10) & 31;
      if (((d >> 15) & 1) == 1 && sh_impl(m_shsel)) m_sh[m_shsel] = d & 'h3FF;
    end else if (a == 'h17) begin
      m_esel = d;
    end else if (a == 'h15) begin
      bank = (m_esel >> 8) & 255;
      r = m_esel & 255;
      if (bank == 'h0E && r == 0) m_s2c = d;
      if (bank == 'h0E && r == 'h15) m_s2s = d;
      if (bank == 'h0F && r < GEN_DEPTH) m_gen[r] = d;
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string rtag);
    check("R2", "reg_rvalid", int'(reg_rvalid), m_rdv);
    check(rtag, "reg_rdata", int'(reg_rdata), m_rd);
    check("R5", "serdes2_en", int'(serdes2_en), m_sh['h14] & 1);
    check("R5", "serdes2_led_src", int'(serdes2_led_src), (m_sh['h14] >> 3) & 1);
    check("R5", "basex_mode", int'(basex_mode), m_sh['h1F] & 1);
    check("R5", "led1_src", int'(led1_src), m_sh['h0D] & 15);
    check("R5", "led3_src", int'(led3_src), (m_sh['h0D] >> 4) & 15);
    check("R9", "serdes2_pwrdn", int'(serdes2_pwrdn), (m_s2c >> 11) & 1);
    check("R9", "sgmii_slave_en", int'(sgmii_slave_en), (m_s2s >> 1) & 1);
    check("R9", "sgmii_autodet", int'(sgmii_autodet), m_s2s & 1);
  endtask

  function automatic string tag_for(int a);
    case (a)
      'h1C: return "R4";
      'h17: return "R7";
      'h15: return "R8";
      default: return "R11";
    endcase
  endfunction

  // drive at a falling edge, predict, compare at the next falling edge
  task automatic apply(int a, bit we, bit re, int d, string rtag);
    reg_addr = 5'(a); reg_wr = we; reg_rd = re; reg_wdata = 16'(d);
    m_rdv = re;
    m_rd = re ? model_read(a) : 0;
    if (we) model_write(a, d);
    @(negedge clk);
    compare_all(rtag);
  endtask

  task automatic wr(int a, int d, string t); apply(a, 1, 0, d, t); endtask
  task automatic rd(int a, string t);        apply(a, 0, 1, 0, t); endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R1");                     // R1 reset state
    rst = 1'b0;
    @(negedge clk);
    compare_all("R1");

    // R3: shadow write stores data, R5 decodes it
    wr('h1C, 'h8000 | ('h14 << 10) | 'h009, "R3");
    wr('h1C, ('h14 << 10), "R3");          // selector only
    rd('h1C, "R4");
    wr('h1C, 'h8000 | ('h0D << 10) | 'h013, "R5");
    wr('h1C, 'h8000 | ('h1F << 10) | 'h001, "R5");
    rd('h1C, "R4");
    // R6: unimplemented selector
    wr('h1C, 'h8000 | ('h05 << 10) | 'h3FF, "R6");
    rd('h1C, "R6");
    // R7 / R9: SerDes bank through the window
    wr('h17, 'h0E15, "R7");
    rd('h17, "R7");
    rd('h15, "R9");
    wr('h15, 'h0003, "R9");
    wr('h17, 'h0E00, "R7");
    rd('h15, "R9");
    wr('h15, 'h0000, "R9");
    wr('h17, 'h0E07, "R9");
    rd('h15, "R9");
    // R8: closed window
    wr('h17, 'h0000, "R8");
    wr('h15, 'h0800, "R8");
    rd('h15, "R8");
    wr('h17, 'h0E00, "R8");
    rd('h15, "R8");
    // R10: general bank in and out of range
    wr('h17, 'h0F03, "R10");
    wr('h15, 'hBEEF, "R10");
    rd('h15, "R10");
    wr('h17, 'h0F20, "R10");
    wr('h15, 'h1234, "R10");
    rd('h15, "R10");
    // R11: inert direct address
    wr('h00, 'hFFFF, "R11");
    rd('h00, "R11");
    // R12: read and write together
    wr('h17, 'h0F03, "R12");
    apply('h15, 1, 1, 'h5555, "R12");
    rd('h15, "R12");
    apply('h1C, 1, 1, 'h8000 | ('h0D << 10) | 'h0A5, "R12");
    rd('h1C, "R12");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int pick = $urandom_range(0, 9);
      int a, d;
      bit we = $urandom_range(0, 1) == 1;
      bit re = $urandom_range(0, 2) != 0;
      d = int'($urandom) & 'hFFFF;
      if (pick < 3) begin
        a = 'h1C;
        case ($urandom_range(0, 3))
          0: d = (d & 'h83FF) | ('h0D << 10);
          1: d = (d & 'h83FF) | ('h14 << 10);
          2: d = (d & 'h83FF) | ('h1F << 10);
          default: ;
        endcase
      end else if (pick < 5) begin
        a = 'h17;
        case ($urandom_range(0, 3))
          0: d = 'h0E00 | ($urandom_range(0, 1) ? 'h15 : 'h00);
          1: d = 'h0F00 | $urandom_range(0, GEN_DEPTH + 3);
          2: d = d & 'h00FF;
          default: ;
        endcase
      end else if (pick < 9) a = 'h15;
      else a = $urandom_range(0, 31);
      apply(a, we, re, d, tag_for(a));
    end

    reg_wr = 1'b0; reg_rd = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule